// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

The core runs one instruction to completion in every clock cycle. On each cycle it fetches the word at the program counter, decodes it and reads two registers. It then computes with the ALU, accesses data memory, writes the result back and selects the next program counter. It supports a small integer subset: word load and store; register add, subtract, AND, OR and signed set-less-than; branch when two registers are equal; and an absolute jump inside the current 256 MB region.

Instruction memory and data memory sit outside the core as two separate word arrays, and both are read combinationally. The core drives a byte address to each array and a write strobe to the data array. Its register write-back (enable, index, value) is also brought out, so the effect of every instruction can be observed.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset, held high at a rising edge, sets the program counter to 0 and clears all 32 registers to zero.
- R2: The instruction address output always equals the program counter. Every instruction except a taken branch or a jump sets the next program counter to PC+4.
- R3: An opcode of 0 with shamt (bits 10-6) equal to 0 is a register operation. It reads rs (bits 25-21) and rt (bits 20-16) and writes rd (bits 15-11). The funct field (bits 5-0) selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than, which gives 1 or 0.
- R4: Opcode 0x23 loads a word. The data address is rs plus the 16-bit immediate (bits 15-0), sign-extended. The data read from that address is written to rt.
- R5: Opcode 0x2B stores a word. It raises the data write strobe, places rs plus the sign-extended immediate on the data address and places rt on the write data. It does not write a register.
- R6: Opcode 0x04 branches when rs equals rt. A taken branch goes to PC+4 plus the sign-extended immediate times 4, and an untaken branch goes to PC+4. A branch writes neither a register nor memory.
- R7: Opcode 0x02 jumps to {PC+4[31:28], bits 25-0, 2'b00}. A jump writes neither a register nor memory.
- R8: Register 0 always reads as zero. A write that targets register 0 is dropped, and the write-back enable stays low for it.
- R9: Any other opcode, and any register operation with an unlisted funct or a nonzero shamt, writes neither a register nor memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Instruction byte address (the program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the rising edge |
| dmem_rdata | input | 32 | Data word at dmem_addr |
| wb_en | output | 1 | A register is written at this edge |
| wb_addr | output | 5 | Index of the register written |
| wb_data | output | 32 | Value written |

## Verification
The first pattern is a directed prologue. It loads one positive and one negative word, writes to register 0, and stores a register that was never written. It also runs a signed set-less-than on operands of opposite sign, a taken branch over a store, an illegal opcode and a jump. These steps separate a correct signed compare from an unsigned one, show whether register 0 and the reset values hold, and confirm that branch and jump targets are exact. After the prologue, a seeded random stream mixes all instruction classes with illegal encodings, branches whose operands are equal about half the time, and jumps to random targets. A reference model in the bench predicts the program counter, the store traffic and the write-back on every cycle. This exposes wrong operand selection, a write-back to the wrong register, lost sign extension, and writes issued by instructions that must stay quiet.

// File: rtl/sc_core.sv
module sc_core (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic        wb_en,
  output logic [4:0]  wb_addr,
  output logic [31:0] wb_data
);
  localparam logic [3:0] CTL_AND = 4'b0000, CTL_OR = 4'b0001, CTL_ADD = 4'b0010,
                         CTL_SUB = 4'b0110, CTL_SLT = 4'b0111, CTL_BAD = 4'b1111;

  logic [31:0] pc, pc_next;
  logic [31:0] rf [32];

  wire [5:0]  op    = imem_rdata[31:26];
  wire [4:0]  rs    = imem_rdata[25:21];
  wire [4:0]  rt    = imem_rdata[20:16];
  wire [4:0]  rd    = imem_rdata[15:11];
  wire [4:0]  shamt = imem_rdata[10:6];
  wire [5:0]  funct = imem_rdata[5:0];
  wire [31:0] sext  = {{16{imem_rdata[15]}}, imem_rdata[15:0]};

  logic       reg_dst, alu_src, mem_to_reg, reg_write, mem_write, branch, jump;
  logic [1:0] alu_op;
  logic [3:0] alu_ctl;

  always_comb begin
    reg_dst = 1'b0; alu_src = 1'b0; mem_to_reg = 1'b0; reg_write = 1'b0;
    mem_write = 1'b0; branch = 1'b0; jump = 1'b0; alu_op = 2'b00;
    case (op)
      6'h00: begin reg_dst = 1'b1; reg_write = 1'b1; alu_op = 2'b10; end
      6'h23: begin alu_src = 1'b1; mem_to_reg = 1'b1; reg_write = 1'b1; end
      6'h2B: begin alu_src = 1'b1; mem_write = 1'b1; end
      6'h04: begin branch = 1'b1; alu_op = 2'b01; end
      6'h02: jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (alu_op)
      2'b00: alu_ctl = CTL_ADD;
      2'b01: alu_ctl = CTL_SUB;
      2'b10: begin
        if (shamt != 5'd0) alu_ctl = CTL_BAD;
        else case (funct)
          6'h20: alu_ctl = CTL_ADD;
          6'h22: alu_ctl = CTL_SUB;
          6'h24: alu_ctl = CTL_AND;
          6'h25: alu_ctl = CTL_OR;
          6'h2A: alu_ctl = CTL_SLT;
          default: alu_ctl = CTL_BAD;
        endcase
      end
      default: alu_ctl = CTL_BAD;
    endcase
  end

  wire [31:0] rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  wire [31:0] rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];
  wire [31:0] alu_b  = alu_src ? sext : rt_val;

  logic [31:0] alu_y;
  always_comb begin
    case (alu_ctl)
      CTL_AND: alu_y = rs_val & alu_b;
      CTL_OR:  alu_y = rs_val | alu_b;
      CTL_ADD: alu_y = rs_val + alu_b;
      CTL_SUB: alu_y = rs_val - alu_b;
      CTL_SLT: alu_y = {31'd0, $signed(rs_val) < $signed(alu_b)};
      default: alu_y = 32'd0;
    endcase
  end
  wire alu_zero = (alu_y == 32'd0);

  wire [31:0] pc_plus4   = pc + 32'd4;
  wire [31:0] br_target  = pc_plus4 + {sext[29:0], 2'b00};
  wire [31:0] jmp_target = {pc_plus4[31:28], imem_rdata[25:0], 2'b00};
  wire        pc_src     = branch & alu_zero;

  always_comb begin
    if (jump)        pc_next = jmp_target;
    else if (pc_src) pc_next = br_target;
    else             pc_next = pc_plus4;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = mem_write;
  assign wb_addr    = reg_dst ? rd : rt;
  assign wb_data    = mem_to_reg ? dmem_rdata : alu_y;
  assign wb_en      = reg_write && (alu_ctl != CTL_BAD) && (wb_addr != 5'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else begin
      pc <= pc_next;
      if (wb_en) rf[wb_addr] <= wb_data;
    end
  end

  wire seq_op = !branch && !jump;

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    seq_op |=> (imem_addr == $past(imem_addr) + 32'd4));

  assert_store_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !wb_en);

  assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
    jump |=> (imem_addr[27:0] == {$past(imem_rdata[25:0]), 2'b00}));

  assert_r0_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (dmem_we && rt == 5'd0) |-> (dmem_wdata == 32'd0));

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_write && alu_ctl == CTL_BAD) |-> (!wb_en && !dmem_we));
endmodule

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;
  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, wb_data;
  logic dmem_we, wb_en;
  logic [4:0] wb_addr;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  logic [31:0] mdm  [256];
  logic [31:0] mreg [32];
  logic [31:0] mpc;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sc_core u0 (.clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
              .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
              .dmem_rdata(dmem_rdata), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data));

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(input logic [4:0] s, t, d, input logic [5:0] f);
    return {6'h00, s, t, d, 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] o, input logic [4:0] s, t, input logic [15:0] im);
    return {o, s, t, im};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rand_instr();
    logic [4:0] s = 5'($urandom), t = 5'($urandom), d = 5'($urandom);
    logic [15:0] im = 16'($urandom);
    int k = $urandom % 16;
    logic [5:0] fl [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    if (k <= 5 || k == 15) begin
      if ($urandom % 10 == 0) return {6'h00, s, t, d, 5'($urandom), 6'($urandom)};
      return enc_r(s, t, d, fl[$urandom % 5]);
    end
    if (k <= 8)  return enc_i(6'h23, s, t, im);
    if (k <= 10) return enc_i(6'h2B, s, t, im);
    if (k <= 12) return enc_i(6'h04, s, ($urandom % 2) ? s : t, 16'($signed(4'($urandom))));
    if (k == 13) return {6'h02, 26'($urandom % 256)};
    return {6'h3F, 26'($urandom)};
  endfunction

  // Reference model: compares current outputs, then advances one instruction.
  task automatic step();
    logic [31:0] ins = imem[mpc[9:2]];
    logic [5:0] op = ins[31:26], fn = ins[5:0];
    logic [4:0] s = ins[25:21], t = ins[20:16], d = ins[15:11];
    logic [31:0] a = mreg[s], b = mreg[t];
    logic [31:0] sx = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] p4 = mpc + 4, npc = mpc + 4;
    bit e_we = 0, e_wb = 0;
    logic [4:0] e_wa = 0;
    logic [31:0] e_wd = 0, e_ad = 0;
    string tag = "R9";
    chk(imem_addr == mpc, "R2 pc", imem_addr, mpc);
    case (op)
      6'h00: begin
        tag = "R3";
        if (ins[10:6] == 0 && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A)) begin
          e_wa = d; e_wb = (d != 0);
          case (fn)
            6'h20: e_wd = a + b;
            6'h22: e_wd = a - b;
            6'h24: e_wd = a & b;
            6'h25: e_wd = a | b;
            default: e_wd = ($signed(a) < $signed(b)) ? 1 : 0;
          endcase
        end else tag = "R9";
      end
      6'h23: begin tag = "R4"; e_wa = t; e_wb = (t != 0); e_ad = a + sx; e_wd = mdm[e_ad[9:2]]; end
      6'h2B: begin tag = "R5"; e_we = 1; e_ad = a + sx; end
      6'h04: begin tag = "R6"; if (a == b) npc = p4 + {sx[29:0], 2'b00}; end
      6'h02: begin tag = "R7"; npc = {p4[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    chk(dmem_we == e_we, {tag, " store strobe"}, 32'(dmem_we), 32'(e_we));
    if (e_we) begin
      chk(dmem_addr == e_ad, {tag, " store addr"}, dmem_addr, e_ad);
      chk(dmem_wdata == b, {tag, " store data"}, dmem_wdata, b);
    end
    chk(wb_en == e_wb, {tag, (e_wa == 0 && op != 6'h2B) ? " R8 wb_en" : " wb_en"}, 32'(wb_en), 32'(e_wb));
    if (e_wb) begin
      chk(wb_addr == e_wa, {tag, " wb_addr"}, 32'(wb_addr), 32'(e_wa));
      chk(wb_data == e_wd, {tag, " wb_data"}, wb_data, e_wd);
      mreg[e_wa] = e_wd;
    end
    if (e_we) mdm[e_ad[9:2]] = b;
    mpc = npc;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) begin dmem[i] = $urandom; imem[i] = rand_instr(); end
    dmem[0] = 32'h1234_5678;
    dmem[1] = 32'hFFFF_FFF0;
    for (int i = 0; i < 256; i++) mdm[i] = dmem[i];
    for (int i = 0; i < 32; i++) mreg[i] = 0;
    imem[0]  = enc_i(6'h23, 0, 1, 16'd0);
    imem[1]  = enc_i(6'h23, 0, 2, 16'd4);
    imem[2]  = enc_r(1, 2, 0, 6'h20);
    imem[3]  = enc_i(6'h2B, 0, 0, 16'd8);
    imem[4]  = enc_r(2, 1, 3, 6'h2A);
    imem[5]  = enc_i(6'h2B, 0, 3, 16'd12);
    imem[6]  = enc_i(6'h2B, 0, 7, 16'd16);
    imem[7]  = enc_i(6'h04, 1, 1, 16'd1);
    imem[8]  = enc_i(6'h2B, 0, 1, 16'd20);
    imem[9]  = 32'hFC00_0000;
    imem[10] = {6'h02, 26'd16};
    mpc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk(imem_addr == 0, "R1 reset pc", imem_addr, 0);
    for (int c = 0; c < 3000; c++) begin
      if (c == 3)  chk(dmem_we && dmem_wdata == 0, "R8 r0 stays zero", dmem_wdata, 0);
      if (c == 5)  chk(dmem_we && dmem_wdata == 1, "R3 signed slt", dmem_wdata, 1);
      if (c == 6)  chk(dmem_we && dmem_wdata == 0, "R1 reset register", dmem_wdata, 0);
      if (c == 8)  chk(imem_addr == 36 && !dmem_we && !wb_en, "R6 taken branch / R9 illegal", imem_addr, 36);
      if (c == 10) chk(imem_addr == 64, "R7 jump target", imem_addr, 64);
      step();
      @(negedge clk);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule